// File: doc/BRIEF.md
# PHY Management Serial Controller

This block gives software a small register window through which it reaches the management registers of an external Ethernet PHY over the two-wire management bus (a clock line and one bidirectional data line). Software first loads the PHY address and the PHY register number into an address register. For a write it also loads a 16-bit value into a transmit data register. It then sets one bit in a command register to start a write, a read or a link poll.

The controller builds a standard Clause 22 management frame, shifts it out and releases the data line for the PHY's answer on reads. The management clock comes from the system clock through a parameterised divider. While a transaction runs, a busy flag is raised. When the transaction ends, the command bit clears itself, read data appears in the receive data register, and a link poll updates a link-down flag in the status register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command register reads 0, the receive data register reads 0, the busy flag (status bit 1) is 0 and the link-down flag (status bit 0) is 1.
- R2: The address register at offset 0x30 holds the PHY address in bits [4:0] and the PHY register number in bits [12:8]. The transmit data register at offset 0x34 keeps only bits [15:0]. All other bits read back as 0.
- R3: The command register at offset 0x2C starts a write with bit 2, a read with bit 1 and a link poll with bit 0. When several of these bits are written at once, write wins over read and read wins over poll. Only the winning bit is stored.
- R4: The busy flag reads 1 from the clock after the command is accepted until the transaction ends, which is 2*DIV_HALF*(PRE_LEN+32) clocks later. In the same clock the stored command bit clears.
- R5: A command write made while busy is ignored. The command register keeps its value, and the frame in progress is unchanged even if the address or data registers are rewritten meanwhile.
- R6: The management clock is low when idle. During a transaction it spends DIV_HALF system clocks low, then DIV_HALF high, starting low.
- R7: The data line changes only on falling edges of the management clock. A write frame is PRE_LEN ones, then 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and 16 data bits, each field sent MSB first. The output enable stays high for the whole write.
- R8: A read uses opcode 10. The output enable drops from the first turnaround bit to the end of the frame. The 16 data bits are sampled on rising management-clock edges, MSB first, and appear at offset 0x38 when the transaction ends.
- R9: A link poll reads PHY register 1 at the loaded PHY address. At the end it sets the link-down flag to the inverse of bit 2 of the returned value, and it leaves the receive data register unchanged.
- R10: Writes to offsets 0x38 and 0x3C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the line |

## Verification
The bench builds the controller with DIV_HALF=3, an odd half period that no power-of-two shortcut in the divider could satisfy, and with the full 32-bit preamble. At these values one transaction is 384 clocks, so write, read, poll, priority and busy-time command cases all fit in a short run. A behavioural model counts clocks from the accepted command and predicts the clock level, the data bit and the output enable on every cycle. It also acts as the PHY, driving answer bits from its own bit count.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int OFF_CMD    = 'h2C;
   localparam int OFF_ADDR   = 'h30;
   localparam int OFF_TXDATA = 'h34;
   localparam int OFF_RXDATA = 'h38;
   localparam int OFF_STATUS = 'h3C;

   localparam int CMD_WR_BIT   = 2;
   localparam int CMD_RD_BIT   = 1;
   localparam int CMD_POLL_BIT = 0;

   localparam int ST_LINKDN_BIT = 0;
   localparam int ST_BUSY_BIT   = 1;

   localparam logic [4:0] POLL_REG = 5'd1;
   localparam int         LINK_OK_BIT = 2;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_POLL  = 2'd3
   } mgmt_op_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise,
   output logic fall
);

   logic tick;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("mdio_clkgen: DIV_HALF must be at least 1");
      end

      if (DIV_HALF == 1) begin : g_div_direct
         assign tick = en;
      end else begin : g_div_count
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!en) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DIV_HALF - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = en && (cnt_q == CW'(DIV_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc <= 1'b0;
      end else if (!en) begin
         mdc <= 1'b0;
      end else if (tick) begin
         mdc <= ~mdc;
      end
   end

   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   // R6: every half-period tick flips the management clock
   a_r6_clock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> (mdc != $past(mdc)));

   // R6: clock parked low when not enabled
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_read,
   input  logic [4:0]  phy,
   input  logic [4:0]  regad,
   input  logic [15:0] wdata,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        done,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] rx_data
);

   localparam int FL     = PRE_LEN + 32;
   localparam int BW     = $clog2(FL);
   localparam int TA_POS = PRE_LEN + 14;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_frame_shifter: PRE_LEN must be at least 1");
      end
   endgenerate

   logic [FL-1:0] frame_q;
   logic [BW-1:0] bit_q;
   logic          busy_q;
   logic          rd_q;
   logic [15:0]   rx_q;
   logic [FL-1:0] frame_init;

   always_comb begin
      frame_init = {{PRE_LEN{1'b1}}, 2'b01,
                    (is_read ? 2'b10 : 2'b01),
                    phy, regad,
                    (is_read ? 2'b11 : 2'b10),
                    (is_read ? 16'hFFFF : wdata)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         bit_q   <= '0;
         busy_q  <= 1'b0;
         rd_q    <= 1'b0;
      end else if (start && !busy_q) begin
         frame_q <= frame_init;
         bit_q   <= '0;
         busy_q  <= 1'b1;
         rd_q    <= is_read;
      end else if (busy_q && fall) begin
         frame_q <= {frame_q[FL-2:0], 1'b1};
         bit_q   <= bit_q + 1'b1;
         if (bit_q == BW'(FL - 1)) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (busy_q && rise) begin
         rx_q <= {rx_q[14:0], mdio_i};
      end
   end

   assign busy    = busy_q;
   assign done    = busy_q && fall && (bit_q == BW'(FL - 1));
   assign mdio_o  = frame_q[FL-1];
   assign mdio_oe = busy_q && (!rd_q || (bit_q < BW'(TA_POS)));
   assign rx_data = rx_q;

   // R7: data line only moves on a falling management-clock edge
   a_r7_mdio_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall) |=> $stable(mdio_o));

   // R4: the last falling edge ends the transaction
   a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_HALF = 4,
   parameter int PRE_LEN  = 32,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("mdio_mgmt_ctrl: ADDR_W must be at least 8");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("mdio_mgmt_ctrl: DATA_W must be at least 16");
      end
   endgenerate

   logic [2:0]  cmd_q;
   logic [4:0]  phy_q;
   logic [4:0]  regad_q;
   logic [15:0] txd_q;
   logic [15:0] rxd_q;
   logic        linkdn_q;

   logic        cmd_wr;
   logic        busy;
   logic        start;
   mgmt_op_e    pick;
   logic [2:0]  pick_bits;
   logic        sh_busy;
   logic        sh_done;
   logic        rise;
   logic        fall;
   logic [15:0] rx_data;

   assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFF_CMD));
   assign busy   = |cmd_q;

   always_comb begin
      pick      = OP_NONE;
      pick_bits = 3'b000;
      if (reg_wdata[CMD_WR_BIT]) begin
         pick = OP_WRITE;
         pick_bits[CMD_WR_BIT] = 1'b1;
      end else if (reg_wdata[CMD_RD_BIT]) begin
         pick = OP_READ;
         pick_bits[CMD_RD_BIT] = 1'b1;
      end else if (reg_wdata[CMD_POLL_BIT]) begin
         pick = OP_POLL;
         pick_bits[CMD_POLL_BIT] = 1'b1;
      end
   end

   assign start = cmd_wr && !busy && (pick != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         phy_q    <= '0;
         regad_q  <= '0;
         txd_q    <= '0;
         rxd_q    <= '0;
         linkdn_q <= 1'b1;
      end else begin
         if (start) begin
            cmd_q <= pick_bits;
         end else if (sh_done) begin
            cmd_q <= '0;
            if (cmd_q[CMD_RD_BIT]) begin
               rxd_q <= rx_data;
            end
            if (cmd_q[CMD_POLL_BIT]) begin
               linkdn_q <= ~rx_data[LINK_OK_BIT];
            end
         end
         if (reg_wr && reg_addr == ADDR_W'(OFF_ADDR)) begin
            phy_q   <= reg_wdata[4:0];
            regad_q <= reg_wdata[12:8];
         end
         if (reg_wr && reg_addr == ADDR_W'(OFF_TXDATA)) begin
            txd_q <= reg_wdata[15:0];
         end
      end
   end

   mdio_clkgen #(
      .DIV_HALF (DIV_HALF)
   ) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sh_busy),
      .mdc   (mdc),
      .rise  (rise),
      .fall  (fall)
   );

   mdio_frame_shifter #(
      .PRE_LEN (PRE_LEN)
   ) u_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .is_read (pick != OP_WRITE),
      .phy     (phy_q),
      .regad   ((pick == OP_POLL) ? POLL_REG : regad_q),
      .wdata   (txd_q),
      .rise    (rise),
      .fall    (fall),
      .mdio_i  (mdio_i),
      .busy    (sh_busy),
      .done    (sh_done),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rx_data (rx_data)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFF_CMD):    reg_rdata[2:0] = cmd_q;
         ADDR_W'(OFF_ADDR): begin
            reg_rdata[4:0]  = phy_q;
            reg_rdata[12:8] = regad_q;
         end
         ADDR_W'(OFF_TXDATA): reg_rdata[15:0] = txd_q;
         ADDR_W'(OFF_RXDATA): reg_rdata[15:0] = rxd_q;
         ADDR_W'(OFF_STATUS): begin
            reg_rdata[ST_LINKDN_BIT] = linkdn_q;
            reg_rdata[ST_BUSY_BIT]   = busy;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R3: at most one command bit is ever stored
   a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q));

   // R5: a command written while busy leaves the command register alone
   a_r5_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr && !sh_done) |=> (cmd_q == $past(cmd_q)));

   // R4: completion clears the command bit
   a_r4_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |=> (cmd_q == 3'b000));

   // R4: the command register and the frame shifter agree on busy
   a_r4_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
      busy == sh_busy);

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

   localparam int H   = 3;
   localparam int PRE = 32;
   localparam int FL  = PRE + 32;
   localparam int TXN = FL * 2 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h3C;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // behavioural model state
   bit          m_busy = 0;
   int          n = 0;
   logic [FL-1:0] m_frame;
   bit          m_write = 0;
   bit          m_poll = 0;
   logic [4:0]  m_phy = '0;
   logic [4:0]  m_reg = '0;
   logic [15:0] m_txd = '0;
   logic [15:0] m_rxd = '0;
   bit          m_linkdn = 1;
   logic [15:0] phy_resp = '0;

   always #4 clk = ~clk;

   mdio_mgmt_ctrl #(.DIV_HALF(H), .PRE_LEN(PRE), .ADDR_W(8), .DATA_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // model: reacts to the same edges as the design
   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (m_busy) begin
            n++;
            if (n == TXN) begin
               m_busy = 0;
               if (m_poll) m_linkdn = ~phy_resp[2];
               else if (!m_write) m_rxd = phy_resp;
            end
         end else if (reg_wr && reg_addr == 8'h2C && reg_wdata[2:0] != 3'b000) begin
            m_busy  = 1;
            n       = 0;
            m_write = reg_wdata[2];
            m_poll  = !reg_wdata[2] && !reg_wdata[1];
            m_frame = {{PRE{1'b1}}, 2'b01, (m_write ? 2'b01 : 2'b10), m_phy,
                       (m_poll ? 5'd1 : m_reg), 2'b10, m_txd};
         end
         if (reg_wr && reg_addr == 8'h30) begin
            m_phy = reg_wdata[4:0];
            m_reg = reg_wdata[12:8];
         end
         if (reg_wr && reg_addr == 8'h34) m_txd = reg_wdata[15:0];
      end
   end

   // per-cycle pin comparison and PHY answer
   always @(negedge clk) begin
      int b;
      logic e_mdc, e_oe;
      if (rst_n) begin
         b     = n / (2 * H);
         e_mdc = m_busy ? logic'((n / H) % 2) : 1'b0;
         e_oe  = m_busy && (m_write || b < PRE + 14);
         chk("R6 mdc", {31'b0, mdc}, {31'b0, e_mdc});
         chk("R8 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
         if (e_oe) chk("R7 mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[FL-1-b]});
         if (m_busy && !m_write && b >= PRE + 16)
            mdio_i = phy_resp[15 - (b - PRE - 16)];
         else
            mdio_i = 1'b1;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 8'h3C;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
      reg_addr = 8'h3C;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(8'h2C, 32'h0, "R1 cmd reset");
      rd(8'h38, 32'h0, "R1 rxdata reset");
      rd(8'h3C, 32'h1, "R1 status reset");

      // R2 field placement
      wr(8'h30, 32'hFFFF_EA13);
      rd(8'h30, 32'h0000_0A13, "R2 address fields");
      wr(8'h34, 32'h1234_BEEF);
      rd(8'h34, 32'h0000_BEEF, "R2 txdata width");

      // R10 read-only registers
      wr(8'h38, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      rd(8'h38, 32'h0, "R10 rxdata unwritable");
      rd(8'h3C, 32'h1, "R10 status unwritable");

      // R7 write transaction, R4 busy window, R5 ignore while busy
      wr(8'h2C, 32'h4);
      rd(8'h2C, 32'h4, "R3 write bit stored");
      rd(8'h3C, 32'h3, "R4 busy set");
      repeat (40) @(negedge clk);
      wr(8'h2C, 32'h2);
      rd(8'h2C, 32'h4, "R5 cmd unchanged while busy");
      wr(8'h30, 32'h0000_0105);
      wr(8'h34, 32'h0000_8001);
      while (n != TXN - 1) @(negedge clk);
      rd(8'h3C, 32'h3, "R4 busy on last cycle");
      @(negedge clk);
      rd(8'h3C, 32'h1, "R4 busy cleared on time");
      rd(8'h2C, 32'h0, "R4 cmd cleared");

      // second write with new fields (written during busy above)
      wr(8'h2C, 32'h4);
      wait_idle();
      rd(8'h38, 32'h0, "R7 write leaves rxdata");

      // R8 read transaction
      wr(8'h30, 32'h0000_1F01);
      phy_resp = 16'hA5C3;
      wr(8'h2C, 32'h2);
      rd(8'h2C, 32'h2, "R3 read bit stored");
      wait_idle();
      rd(8'h38, 32'h0000_A5C3, "R8 read data");

      // R9 link poll, link up
      phy_resp = 16'h0004;
      wr(8'h2C, 32'h1);
      rd(8'h2C, 32'h1, "R3 poll bit stored");
      wait_idle();
      rd(8'h3C, 32'h0, "R9 link up");
      rd(8'h38, 32'h0000_A5C3, "R9 rxdata untouched");

      // R9 link poll, link down
      phy_resp = 16'hFFFB;
      wr(8'h2C, 32'h1);
      wait_idle();
      rd(8'h3C, 32'h1, "R9 link down");

      // R3 priority
      wr(8'h2C, 32'h7);
      rd(8'h2C, 32'h4, "R3 write wins");
      wait_idle();
      phy_resp = 16'h3C5A;
      wr(8'h2C, 32'h3);
      rd(8'h2C, 32'h2, "R3 read beats poll");
      wait_idle();
      rd(8'h38, 32'h0000_3C5A, "R8 second read data");
      rd(8'h3C, 32'h1, "R3 poll not run");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule